// File: doc/BRIEF.md
# Multi-Agent Hardware Lock Arbiter

This block hands out a single lock to up to sixteen software agents. Each agent has one bit position in two 16-bit registers. In the claim register, writing 1 to a bit places a lock request. In the owner register, at most one bit is set, and that bit names the agent that holds the lock. A value of zero means nobody holds it. The hardware keeps each request pending until the agent is given the lock or the agent withdraws the request. An agent gives the lock back, or withdraws a request it has not yet been granted, by writing 1 to its own bit of the owner register.

Agents use it through a simple register port. Each register has its own write strobe and write data. Both registers are always visible as outputs. When the lock is free, the lowest-numbered waiting agent wins. It becomes owner on the next clock edge, and its claim bit clears on that same edge.

Top module: `lock_arbiter`

## Requirements
- R1: A claim write with data bit i = 1 sets claim bit i on the next clock edge, unless agent i owns the lock, withdraws in the same cycle, or is granted on that edge.
- R2: A claim bit never goes from 0 to 1 except through a claim write with a 1 in that position; bits written 0 are left unchanged.
- R3: The owner register has at most one bit set at any time, and reads 0x0000 while the lock is free.
- R4: An owner-register write with a 1 on the set owner bit clears the owner register on the next edge.
- R5: An owner-register write with a 1 on an unset bit clears that agent's claim bit on the next edge. This withdrawal overrides a claim write to the same bit in the same cycle.
- R6: If the owner register reads 0 and at least one claim bit is pending (and not withdrawn this cycle), the lowest-numbered pending agent's bit is set in the owner register on the next edge, and its claim bit clears on that edge.
- R7: After a release, the owner register reads 0x0000 for at least one cycle before the next grant.
- R8: A claim write to the current owner's bit is ignored. No agent has its claim bit and owner bit set together.
- R9: An active-low reset clears both registers to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| claim_we | input | 1 | Write strobe of the claim register |
| claim_wdata | input | 16 | Claim write data, bit i = agent i |
| owner_we | input | 1 | Write strobe of the owner register |
| owner_wdata | input | 16 | Owner write data: 1 releases (own bit) or withdraws (other bit) |
| claim_q | output | 16 | Pending claim bits |
| owner_q | output | 16 | One-hot owner, zero when free |

## Verification
On every cycle, the embedded assertions check:
- that the owner register stays one-hot or zero;
- that claim and owner bits never overlap;
- that no claim bit rises without a write;
- that a withdrawn claim clears;
- that a release empties the owner register;
- that a free lock with waiting agents is taken on the next edge.

Only the bench scenarios can show the following, because they need the expected sequence of register values:
- that the winner is exactly the lowest-numbered pending agent;
- that a withdrawal beats a simultaneous claim;
- how reset in the middle of a run behaves;
- that long random mixes of writes match a cycle model of the requirements.

// File: rtl/lock_arb_pkg.sv
package lock_arb_pkg;
  localparam int unsigned LOCK_AGENTS_DEFAULT = 16;

  // Result of decoding one owner-register write against the current owner.
  typedef enum logic [1:0] {
    OWN_NONE     = 2'b00,
    OWN_RELEASE  = 2'b01,
    OWN_WITHDRAW = 2'b10,
    OWN_BOTH     = 2'b11
  } own_wr_kind_e;
endpackage

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [WIDTH-1:0] pick_o,
  output logic             any_o
);
  // seen[i] is 1 when some bit below position i is set
  logic [WIDTH:0] seen;

  assign seen[0] = 1'b0;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_chain
    assign pick_o[gi]  = vec_i[gi] & ~seen[gi];
    assign seen[gi+1]  = seen[gi] | vec_i[gi];
  end

  assign any_o = seen[WIDTH];

  always_comb begin
    if (any_o) begin
      assert ($onehot(pick_o)) else $error("pick not one-hot");
    end
  end
endmodule

// File: rtl/claim_bank.sv
module claim_bank #(
  parameter int unsigned AGENTS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en_i,
  input  logic [AGENTS-1:0] set_mask_i,
  input  logic [AGENTS-1:0] owner_i,
  input  logic [AGENTS-1:0] withdraw_i,
  input  logic [AGENTS-1:0] take_i,
  output logic [AGENTS-1:0] claim_q_o
);
  logic [AGENTS-1:0] claim_q, claim_d, add_mask;
  logic              claim_en;

  always_comb begin
    add_mask = set_en_i ? (set_mask_i & ~owner_i) : '0;
    claim_d  = (claim_q | add_mask) & ~withdraw_i & ~take_i;
    claim_en = set_en_i | (|withdraw_i) | (|take_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_q <= '0;
    end else if (claim_en) begin
      claim_q <= claim_d;
    end
  end

  assign claim_q_o = claim_q;

  AST_NO_SPONTANEOUS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    !set_en_i |=> ((claim_q & ~$past(claim_q)) == '0)); // R2

  AST_WITHDRAW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (withdraw_i != '0) |=> ((claim_q & $past(withdraw_i)) == '0)); // R5

  AST_OWNER_CLAIM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en_i && ((set_mask_i & owner_i & ~claim_q) != '0))
      |=> ((claim_q & $past(set_mask_i & owner_i & ~claim_q)) == '0)); // R8
endmodule

// File: rtl/owner_reg.sv
module owner_reg
  import lock_arb_pkg::*;
#(
  parameter int unsigned AGENTS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [AGENTS-1:0] wr_mask_i,
  input  logic [AGENTS-1:0] claim_i,
  output logic [AGENTS-1:0] owner_q_o,
  output logic [AGENTS-1:0] withdraw_o,
  output logic [AGENTS-1:0] take_o
);
  logic [AGENTS-1:0] owner_q, owner_d;
  logic [AGENTS-1:0] release_hit, withdraw, pending, winner;
  logic              any_pending, lock_free, owner_en;
  own_wr_kind_e      wr_kind;

  lowest_pick #(.WIDTH(AGENTS)) i_pick (
    .vec_i  (pending),
    .pick_o (winner),
    .any_o  (any_pending)
  );

  always_comb begin
    release_hit = wr_en_i ? (wr_mask_i & owner_q)  : '0;
    withdraw    = wr_en_i ? (wr_mask_i & ~owner_q) : '0;
    wr_kind     = own_wr_kind_e'({|withdraw, |release_hit});
    lock_free   = (owner_q == '0);
    pending     = claim_i & ~withdraw;
    take_o      = lock_free ? winner : '0;
    owner_en    = lock_free ? any_pending
                            : (wr_kind == OWN_RELEASE || wr_kind == OWN_BOTH);
    owner_d     = lock_free ? winner : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
    end else if (owner_en) begin
      owner_q <= owner_d;
    end
  end

  assign owner_q_o  = owner_q;
  assign withdraw_o = withdraw;

  AST_OWNER_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner_q)); // R3

  AST_RELEASE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (release_hit != '0) |=> (owner_q == '0)); // R4

  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q != '0) |=> ($past(owner_q) == owner_q || owner_q == '0)); // R7

  AST_FREE_IS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_free && any_pending) |=> $onehot(owner_q)); // R6
endmodule

// File: rtl/lock_arbiter.sv
module lock_arbiter
  import lock_arb_pkg::*;
#(
  parameter int unsigned AGENTS = LOCK_AGENTS_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              claim_we,
  input  logic [AGENTS-1:0] claim_wdata,
  input  logic              owner_we,
  input  logic [AGENTS-1:0] owner_wdata,
  output logic [AGENTS-1:0] claim_q,
  output logic [AGENTS-1:0] owner_q
);
  logic [AGENTS-1:0] withdraw, take;

  owner_reg #(.AGENTS(AGENTS)) i_owner (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (owner_we),
    .wr_mask_i  (owner_wdata),
    .claim_i    (claim_q),
    .owner_q_o  (owner_q),
    .withdraw_o (withdraw),
    .take_o     (take)
  );

  claim_bank #(.AGENTS(AGENTS)) i_claims (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en_i   (claim_we),
    .set_mask_i (claim_wdata),
    .owner_i    (owner_q),
    .withdraw_i (withdraw),
    .take_i     (take),
    .claim_q_o  (claim_q)
  );

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((claim_q & owner_q) == '0)); // R8
endmodule

// File: tb/test_lock_arbiter.sv
module test_lock_arbiter;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         claim_we, owner_we;
  logic [N-1:0] claim_wdata, owner_wdata;
  logic [N-1:0] claim_q, owner_q;
  logic [N-1:0] m_claim, m_owner;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  lock_arbiter #(.AGENTS(N)) i_lock_arbiter (
    .clk, .rst_n, .claim_we, .claim_wdata, .owner_we, .owner_wdata,
    .claim_q, .owner_q
  );

  function automatic logic [N-1:0] lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
    return '0;
  endfunction

  // Next {claim, owner} computed from the requirements
  function automatic logic [2*N-1:0] model_next(
    input logic [N-1:0] c, input logic [N-1:0] o,
    input logic cwe, input logic [N-1:0] cwd,
    input logic owe, input logic [N-1:0] owd);
    logic [N-1:0] wd, rel, add, win, nc, no;
    wd  = owe ? (owd & ~o) : '0;
    rel = owe ? (owd & o)  : '0;
    add = cwe ? (cwd & ~o) : '0;
    win = (o == '0) ? lowest(c & ~wd) : '0;
    nc  = (c | add) & ~wd & ~win;
    no  = (o == '0) ? win : ((rel != '0) ? '0 : o);
    return {nc, no};
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic cwe, input logic [N-1:0] cwd,
                      input logic owe, input logic [N-1:0] owd);
    logic [2*N-1:0] nx;
    claim_we = cwe; claim_wdata = cwd; owner_we = owe; owner_wdata = owd;
    nx = model_next(m_claim, m_owner, cwe, cwd, owe, owd);
    @(posedge clk); #1;
    {m_claim, m_owner} = nx;
    claim_we = 1'b0; owner_we = 1'b0; claim_wdata = '0; owner_wdata = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    claim_we = 1'b0; owner_we = 1'b0; claim_wdata = '0; owner_wdata = '0;
    #12;
    m_claim = '0; m_owner = '0;
    check("R9 reset claim", claim_q, 16'h0000);
    check("R9 reset owner", owner_q, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #900000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int unsigned seed;
    logic [N-1:0] cw, ow;
    do_reset();

    step(1'b1, 16'h0008, 1'b0, '0);
    check("R1 claim set", claim_q, 16'h0008);
    check("R1 owner still free", owner_q, 16'h0000);
    step(1'b0, '0, 1'b0, '0);
    check("R6 grant owner", owner_q, 16'h0008);
    check("R6 claim cleared on grant", claim_q, 16'h0000);

    step(1'b1, 16'h0220, 1'b0, '0);
    check("R1 two claims", claim_q, 16'h0220);
    step(1'b1, 16'h0000, 1'b0, '0);
    check("R2 zero write", claim_q, 16'h0220);
    step(1'b1, 16'h0008, 1'b0, '0);
    check("R8 owner claim ignored", claim_q, 16'h0220);
    check("R8 owner kept", owner_q, 16'h0008);

    step(1'b0, '0, 1'b1, 16'h0200);
    check("R5 withdraw agent 9", claim_q, 16'h0020);
    check("R5 owner unchanged", owner_q, 16'h0008);

    step(1'b1, 16'hC010, 1'b1, 16'h0008);
    check("R4 release", owner_q, 16'h0000);
    check("R7 gap after release", claim_q, 16'hC030);
    step(1'b1, 16'h0004, 1'b1, 16'h0004);
    check("R6 lowest wins", owner_q, 16'h0010);
    check("R5 withdraw beats claim", claim_q, 16'hC020);
    step(1'b0, '0, 1'b1, 16'h0010);
    check("R3 free reads zero", owner_q, 16'h0000);
    step(1'b0, '0, 1'b0, '0);
    check("R6 next lowest", owner_q, 16'h0020);

    do_reset();

    seed = 32'd1234;
    void'($urandom(seed));
    for (int k = 0; k < 4000; k++) begin
      cw = N'($urandom()) & N'($urandom());
      ow = lowest(N'($urandom())) | ((k % 7 == 0) ? m_owner : '0);
      step(($urandom() % 3) == 0, cw, ($urandom() % 4) == 0, ow);
      check("R1 random claim", claim_q, m_claim);
      check("R6 random owner", owner_q, m_owner);
      checks++;
      if (!$onehot0(owner_q) || ((owner_q & claim_q) != '0)) begin
        errors++;
        $display("FAIL R3 onehot/overlap: actual=%h/%h expected=onehot0,disjoint", owner_q, claim_q);
      end
    end
    finish_run();
  end
endmodule